// File: doc/BRIEF.md
# Shared Bus Ownership Arbiter

This block decides which of two masters owns a shared external bus: the on-chip processor, or a master that sits outside the chip. Each master raises its own request line and receives its own acknowledge line. A master drives the bus only while its acknowledge is high. The outside master has the higher fixed priority.

The arbiter looks at both requests on every clock, but it never takes the bus away from an owner at once. The processor gives up the bus only at points where it raises its release-ready input, or when it stops requesting. The outside master keeps the bus for as long as it requests it. While ownership passes from one master to the other, neither acknowledge is high for a configurable number of idle cycles. During those cycles the arbiter holds the address, lets go of the data bus, and drives every strobe inactive high. When nobody requests, the last owner stays parked on the bus.

Top module: `xbus_owner_arbiter`

## Requirements
- R1: While reset is active and on the first cycle after it, cpu_ack is 1 and ext_ack is 0.
- R2: cpu_ack and ext_ack are never 1 in the same cycle.
- R3: When the processor owns the bus, still requests it and has cpu_rel_ok low, cpu_ack stays 1 on the next cycle, even if ext_req is high.
- R4: When the processor owns the bus with ext_req and cpu_rel_ok both high at a clock edge, cpu_ack is 0 after that edge. ext_ack goes to 1 once IDLE_CYCLES idle cycles have passed (default 1), provided ext_req is still high.
- R5: If the owner drops its request while the other master is requesting, the owner loses its acknowledge on the next edge, and the other master is granted after the idle cycles.
- R6: If neither master requests, both acknowledges keep their values (parking).
- R7: While the outside master owns the bus and keeps ext_req high, cpu_req has no effect and ext_ack stays 1.
- R8: In a cycle with neither acknowledge high, bus_strb_n is all ones, bus_data_oe is 0 and addr_hold is 1. The strobe bits are ordered [4] chip select, [3] address strobe, [2] read, [1] high write, [0] low write.
- R9: While a master owns the bus, bus_strb_n equals that master's strobe input, bus_data_oe equals that master's data enable, and addr_hold is 0.
- R10: At the end of the idle cycles, the outside master is granted if ext_req is high. Otherwise the processor is granted if cpu_req is high. Otherwise the master chosen when the handover began is granted.
- R11: An acknowledge rises only in a cycle that follows a cycle in which the other acknowledge was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor bus request |
| cpu_rel_ok | input | 1 | Processor is at a point where it may release the bus |
| ext_req | input | 1 | Outside master bus request |
| cpu_strb_n | input | NSTB | Processor strobes, active low |
| ext_strb_n | input | NSTB | Outside master strobes, active low |
| cpu_data_oe | input | 1 | Processor data drive enable |
| ext_data_oe | input | 1 | Outside master data drive enable |
| cpu_ack | output | 1 | Processor owns the bus |
| ext_ack | output | 1 | Outside master owns the bus |
| addr_hold | output | 1 | Address held during an idle cycle |
| bus_data_oe | output | 1 | Data bus drive enable; 0 means high impedance |
| bus_strb_n | output | NSTB | Strobes driven to the bus, active low |

## Verification
The bench holds the processor's request and the outside request high together while cpu_rel_ok stays low, to catch a design that preempts at once. It then pulses release-ready for a single cycle and checks that the grant arrives after exactly one idle cycle and not sooner, so a design with no gap would show both acknowledges high. Requests are changed during the idle cycle to expose a grant frozen at the start of the handover. The bench also drops all requests to show a design that lets go of a parked bus. Random request and strobe traffic is compared every cycle against a reference model, which catches strobes or data enable that leak through while the bus is unowned.

// File: rtl/xbus_arb_pkg.sv
package xbus_arb_pkg;
  typedef enum logic [1:0] {
    OWN_CPU  = 2'd0,
    OWN_EXT  = 2'd1,
    HANDOVER = 2'd2
  } own_e;
endpackage

// File: rtl/xbus_arb_decide.sv
module xbus_arb_decide
  import xbus_arb_pkg::*;
(
  input  own_e state,
  input  own_e target,
  input  logic cpu_req,
  input  logic cpu_rel_ok,
  input  logic ext_req,
  input  logic idle_done,
  output own_e state_nxt,
  output own_e target_nxt,
  output logic start_idle
);
  always_comb begin
    state_nxt  = state;
    target_nxt = target;
    start_idle = 1'b0;
    unique case (state)
      OWN_CPU: begin
        if (ext_req && (cpu_rel_ok || !cpu_req)) begin
          state_nxt  = HANDOVER;
          target_nxt = OWN_EXT;
          start_idle = 1'b1;
        end
      end
      OWN_EXT: begin
        if (!ext_req && cpu_req) begin
          state_nxt  = HANDOVER;
          target_nxt = OWN_CPU;
          start_idle = 1'b1;
        end
      end
      HANDOVER: begin
        if (idle_done) begin
          if (ext_req)      state_nxt = OWN_EXT;
          else if (cpu_req) state_nxt = OWN_CPU;
          else              state_nxt = target;
        end
      end
      default: state_nxt = OWN_CPU;
    endcase
  end
endmodule

// File: rtl/xbus_arb_idle_ctl.sv
module xbus_arb_idle_ctl #(
  parameter int IDLE_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  output logic done
);
  localparam int CW = (IDLE_CYCLES > 1) ? $clog2(IDLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done = active && (cnt_q == LAST);

  always_comb begin
    cnt_en = start || (active && !done);
    cnt_d  = start ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/xbus_arb_pin_mux.sv
module xbus_arb_pin_mux #(
  parameter int NSTB = 5
) (
  input  logic            sel_cpu,
  input  logic            sel_ext,
  input  logic [NSTB-1:0] cpu_strb_n,
  input  logic [NSTB-1:0] ext_strb_n,
  input  logic            cpu_data_oe,
  input  logic            ext_data_oe,
  output logic            addr_hold,
  output logic            bus_data_oe,
  output logic [NSTB-1:0] bus_strb_n
);
  logic idle;
  assign idle        = !sel_cpu && !sel_ext;
  assign addr_hold   = idle;
  assign bus_data_oe = (sel_cpu && cpu_data_oe) || (sel_ext && ext_data_oe);

  for (genvar i = 0; i < NSTB; i++) begin : g_strb
    always_comb begin
      if (sel_cpu)      bus_strb_n[i] = cpu_strb_n[i];
      else if (sel_ext) bus_strb_n[i] = ext_strb_n[i];
      else              bus_strb_n[i] = 1'b1;
    end
  end
endmodule

// File: rtl/xbus_owner_arbiter.sv
module xbus_owner_arbiter
  import xbus_arb_pkg::*;
#(
  parameter int IDLE_CYCLES = 1,
  parameter int NSTB        = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_req,
  input  logic            cpu_rel_ok,
  input  logic            ext_req,
  input  logic [NSTB-1:0] cpu_strb_n,
  input  logic [NSTB-1:0] ext_strb_n,
  input  logic            cpu_data_oe,
  input  logic            ext_data_oe,
  output logic            cpu_ack,
  output logic            ext_ack,
  output logic            addr_hold,
  output logic            bus_data_oe,
  output logic [NSTB-1:0] bus_strb_n
);
  own_e state_q, state_d, target_q, target_d;
  logic start_idle, idle_done, st_en;

  xbus_arb_decide u_decide (
    .state      (state_q),
    .target     (target_q),
    .cpu_req    (cpu_req),
    .cpu_rel_ok (cpu_rel_ok),
    .ext_req    (ext_req),
    .idle_done  (idle_done),
    .state_nxt  (state_d),
    .target_nxt (target_d),
    .start_idle (start_idle)
  );

  xbus_arb_idle_ctl #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_idle),
    .active (state_q == HANDOVER),
    .done   (idle_done)
  );

  assign st_en = (state_d != state_q) || (target_d != target_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= OWN_CPU;
      target_q <= OWN_CPU;
    end else if (st_en) begin
      state_q  <= state_d;
      target_q <= target_d;
    end
  end

  assign cpu_ack = (state_q == OWN_CPU);
  assign ext_ack = (state_q == OWN_EXT);

  xbus_arb_pin_mux #(.NSTB(NSTB)) u_pins (
    .sel_cpu     (cpu_ack),
    .sel_ext     (ext_ack),
    .cpu_strb_n  (cpu_strb_n),
    .ext_strb_n  (ext_strb_n),
    .cpu_data_oe (cpu_data_oe),
    .ext_data_oe (ext_data_oe),
    .addr_hold   (addr_hold),
    .bus_data_oe (bus_data_oe),
    .bus_strb_n  (bus_strb_n)
  );
endmodule

// File: rtl/xbus_owner_arbiter_chk.sv
module xbus_owner_arbiter_chk #(
  parameter int NSTB = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_req,
  input logic            cpu_rel_ok,
  input logic            ext_req,
  input logic            cpu_ack,
  input logic            ext_ack,
  input logic            addr_hold,
  input logic            bus_data_oe,
  input logic [NSTB-1:0] bus_strb_n
);
  assert_ack_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_ack && ext_ack));

  assert_no_preempt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_req && !cpu_rel_ok) |=> cpu_ack);

  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && ext_req && cpu_rel_ok) |=> !cpu_ack);

  assert_park_cpu_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !cpu_req && !ext_req) |=> cpu_ack);

  assert_park_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_ack && !cpu_req && !ext_req) |=> ext_ack);

  assert_ext_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_ack && ext_req) |=> ext_ack);

  assert_idle_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_ack && !ext_ack) |-> (&bus_strb_n && !bus_data_oe && addr_hold));

  assert_gap_ext_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_ack) |-> !$past(cpu_ack));

  assert_gap_cpu_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_ack) |-> !$past(ext_ack));
endmodule

bind xbus_owner_arbiter xbus_owner_arbiter_chk #(.NSTB(NSTB)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_req     (cpu_req),
  .cpu_rel_ok  (cpu_rel_ok),
  .ext_req     (ext_req),
  .cpu_ack     (cpu_ack),
  .ext_ack     (ext_ack),
  .addr_hold   (addr_hold),
  .bus_data_oe (bus_data_oe),
  .bus_strb_n  (bus_strb_n)
);

// File: tb/test_xbus_owner_arbiter.sv
module test_xbus_owner_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int IC   = 1;
  localparam int NSTB = 5;

  logic clk, rst_n;
  logic cpu_req, cpu_rel_ok, ext_req, cpu_data_oe, ext_data_oe;
  logic [NSTB-1:0] cpu_strb_n, ext_strb_n, bus_strb_n;
  logic cpu_ack, ext_ack, addr_hold, bus_data_oe;

  int total, bad, cycles;
  int ms, tgt, cnt;

  xbus_owner_arbiter #(.IDLE_CYCLES(IC), .NSTB(NSTB)) i_xbus_owner_arbiter (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_rel_ok(cpu_rel_ok),
    .ext_req(ext_req), .cpu_strb_n(cpu_strb_n), .ext_strb_n(ext_strb_n),
    .cpu_data_oe(cpu_data_oe), .ext_data_oe(ext_data_oe),
    .cpu_ack(cpu_ack), .ext_ack(ext_ack), .addr_hold(addr_hold),
    .bus_data_oe(bus_data_oe), .bus_strb_n(bus_strb_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected strobe/oe/hold packed for comparison
  function automatic logic [15:0] exp_pins(int s);
    logic [NSTB-1:0] st;
    logic oe, hold;
    if (s == 0)      begin st = cpu_strb_n; oe = cpu_data_oe; hold = 1'b0; end
    else if (s == 1) begin st = ext_strb_n; oe = ext_data_oe; hold = 1'b0; end
    else             begin st = '1;         oe = 1'b0;        hold = 1'b1; end
    return {9'd0, hold, oe, st};
  endfunction

  // Next owner per the requirements: 0 cpu, 1 ext, 2 handover
  task automatic model_step();
    case (ms)
      0: if (ext_req && (cpu_rel_ok || !cpu_req)) begin ms = 2; tgt = 1; cnt = 0; end
      1: if (!ext_req && cpu_req) begin ms = 2; tgt = 0; cnt = 0; end
      default: begin
        if (cnt == IC - 1) ms = ext_req ? 1 : (cpu_req ? 0 : tgt);
        else cnt++;
      end
    endcase
  endtask

  task automatic compare();
    logic [15:0] pins;
    pins = {9'd0, addr_hold, bus_data_oe, bus_strb_n};
    check(!(cpu_ack && ext_ack), "R2 acks exclusive", {14'd0, cpu_ack, ext_ack}, 16'd0);
    check({cpu_ack, ext_ack} == {ms == 0, ms == 1}, "R4 ack model",
          {14'd0, cpu_ack, ext_ack}, {14'd0, ms == 0, ms == 1});
    check(pins == exp_pins(ms), (ms == 2) ? "R8 idle pins" : "R9 owner pins", pins, exp_pins(ms));
  endtask

  task automatic step(input logic cr, input logic rel, input logic er);
    @(negedge clk);
    cpu_req = cr; cpu_rel_ok = rel; ext_req = er;
    cpu_strb_n = NSTB'($urandom); ext_strb_n = NSTB'($urandom);
    cpu_data_oe = 1'($urandom); ext_data_oe = 1'($urandom);
    @(posedge clk);
    #1;
    model_step();
    compare();
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    total = 0; bad = 0;
    ms = 0; tgt = 0; cnt = 0;
    rst_n = 1'b0;
    cpu_req = 0; cpu_rel_ok = 0; ext_req = 0;
    cpu_strb_n = '0; ext_strb_n = '0; cpu_data_oe = 1; ext_data_oe = 1;
    #(CLK_PERIOD * 3 + 2);
    check(cpu_ack && !ext_ack, "R1 reset owner", {14'd0, cpu_ack, ext_ack}, 16'h2);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check(cpu_ack && !ext_ack, "R1 after reset", {14'd0, cpu_ack, ext_ack}, 16'h2);

    // R3: both request, no release point
    for (int i = 0; i < 4; i++) step(1, 0, 1);
    check(cpu_ack && !ext_ack, "R3 no preemption", {14'd0, cpu_ack, ext_ack}, 16'h2);
    // R4: release point pulse
    step(1, 1, 1);
    check(!cpu_ack && !ext_ack, "R4 idle after release", {14'd0, cpu_ack, ext_ack}, 16'h0);
    check(&bus_strb_n && !bus_data_oe && addr_hold, "R8 handover pins",
          {9'd0, addr_hold, bus_data_oe, bus_strb_n}, 16'h5f);
    step(1, 0, 1);
    check(!cpu_ack && ext_ack, "R4 ext granted after one idle", {14'd0, cpu_ack, ext_ack}, 16'h1);
    // R7: ext keeps bus
    for (int i = 0; i < 5; i++) step(1, 1, 1);
    check(ext_ack, "R7 ext kept", {15'd0, ext_ack}, 16'h1);
    // R6: parking on ext
    for (int i = 0; i < 4; i++) step(0, 0, 0);
    check(ext_ack && !cpu_ack, "R6 ext parked", {14'd0, cpu_ack, ext_ack}, 16'h1);
    // R5: ext drops, cpu requests
    step(1, 0, 0);
    check(!cpu_ack && !ext_ack, "R5 ext released", {14'd0, cpu_ack, ext_ack}, 16'h0);
    step(1, 0, 0);
    check(cpu_ack, "R5 cpu granted", {15'd0, cpu_ack}, 16'h1);
    // R6: parking on cpu
    for (int i = 0; i < 3; i++) step(0, 1, 0);
    check(cpu_ack, "R6 cpu parked", {15'd0, cpu_ack}, 16'h1);
    // R10: request changes during idle
    step(1, 1, 1);
    step(1, 0, 0);
    check(cpu_ack && !ext_ack, "R10 cpu regrant", {14'd0, cpu_ack, ext_ack}, 16'h2);
    step(0, 0, 1);
    step(0, 0, 0);
    check(ext_ack && !cpu_ack, "R10 target kept", {14'd0, cpu_ack, ext_ack}, 16'h1);
    // R11 checked by model: random traffic
    for (int i = 0; i < 3000; i++)
      step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 2) == 0));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule